// File: doc/BRIEF.md
# Interrupt Completion and Deactivation Tracker

This block sits in the processor-side interface of an interrupt controller. It follows the life of each interrupt after it has been taken. Every valid acknowledge records the interrupt's ID and priority on a small nesting stack and marks the interrupt as active. A completion write retires the newest entry and so lowers the running priority back to the level that was interrupted. A mode input selects whether that same write also clears the active mark, or whether clearing waits for a separate deactivate write.

Completion and deactivate writes arrive as 32-bit words. The upper byte is reserved. The ID field is 16 or 24 bits wide, chosen by a configuration input. IDs 1020 to 1023 are special and never name a real interrupt. The block checks that each completion names the interrupt on top of its stack. When it does not, the block reports a one-cycle error and changes nothing.

Top module: `irq_retire_tracker`

## Requirements
- R1: After a synchronous reset, `run_prio` is 0xFF, every bit of `active` is 0 and `eoi_err` is 0.
- R2: An `ack_valid` with an ID outside 1020..1023 pushes `ack_prio`. From the next cycle `run_prio` shows that priority, and `active[id]` is 1 for IDs below `TRACK_IDS`. An acknowledge of ID 1020..1023 changes no output.
- R3: Write bits 31:24 are ignored. With `id_wide`=1 the ID is bits 23:0. With `id_wide`=0 it is bits 15:0 and bits 23:16 are taken as zero. The same masking applies to `ack_id` and to deactivate writes.
- R4: A completion whose ID equals the newest recorded ID pops it. `run_prio` then returns to the previous entry's priority, or to 0xFF when nothing is left.
- R5: With `split_mode`=0, a matching completion also clears `active[id]`.
- R6: With `split_mode`=1, a matching completion leaves `active` untouched. A later `dir_valid` write carrying that ID clears `active[id]`.
- R7: A deactivate write is ignored in three cases: when `split_mode`=0, when its ID is not active, and when its ID is special.
- R8: A completion carrying ID 1020..1023 changes no state and raises no error.
- R9: A non-special completion is a fault when the stack is empty or when the ID differs from the newest entry. A fault gives `eoi_err`=1 for exactly the next cycle and leaves `run_prio` and `active` unchanged.
- R10: A valid acknowledge that arrives while 8 (`STACK_DEPTH`) entries are held records nothing and raises `eoi_err` for one cycle.
- R11: When an acknowledge and a matching completion arrive in the same cycle, the completion is judged against the entry that was on top before that edge. The new acknowledge then takes its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_valid | input | 1 | Acknowledge event strobe |
| ack_id | input | 24 | Acknowledged interrupt ID |
| ack_prio | input | 8 | Priority of the acknowledged interrupt |
| eoi_valid | input | 1 | Completion write strobe |
| eoi_data | input | 32 | Completion write word |
| dir_valid | input | 1 | Deactivate write strobe |
| dir_data | input | 32 | Deactivate write word |
| split_mode | input | 1 | 0: completion also deactivates; 1: deactivation is separate |
| id_wide | input | 1 | 1: 24-bit IDs; 0: 16-bit IDs |
| run_prio | output | 8 | Priority of newest active entry, 0xFF when idle |
| active | output | TRACK_IDS | Active flag for IDs 0 to TRACK_IDS-1 |
| eoi_err | output | 1 | One-cycle fault pulse |

## Verification
A corrupted stack entry or count appears on `run_prio` in the cycle right after the event that exposes it. That event is either a completion that should have matched but raises `eoi_err`, or a completion that pops back to the wrong level. A stuck or wrongly cleared active flag appears on `active` one cycle after the acknowledge, completion or deactivate that should have moved it. Because of this, every scenario samples all outputs after each single event rather than only at the end of a sequence.

// File: rtl/irq_retire_pkg.sv
package irq_retire_pkg;

    localparam int ID_W   = 24;
    localparam int PRIO_W = 8;
    localparam int NARROW_W = 16;

    typedef logic [ID_W-1:0]   irq_id_t;
    typedef logic [PRIO_W-1:0] irq_prio_t;

    localparam irq_id_t   SPECIAL_LO = irq_id_t'(1020);
    localparam irq_id_t   SPECIAL_HI = irq_id_t'(1023);
    localparam irq_prio_t IDLE_PRIO  = '1;

    typedef struct packed {
        irq_id_t   id;
        irq_prio_t prio;
    } stack_ent_t;

    typedef struct packed {
        logic    valid;
        logic    special;
        irq_id_t id;
    } id_req_t;

    typedef enum logic [1:0] {
        EOI_IDLE,
        EOI_IGNORE,
        EOI_MATCH,
        EOI_FAULT
    } eoi_kind_e;

    function automatic irq_id_t mask_id(input logic [ID_W-1:0] raw, input logic wide);
        irq_id_t r;
        r = raw;
        if (!wide) r[ID_W-1:NARROW_W] = '0;
        return r;
    endfunction

    function automatic logic is_special(input irq_id_t id);
        return (id >= SPECIAL_LO) && (id <= SPECIAL_HI);
    endfunction

endpackage

// File: rtl/irq_id_decode.sv
module irq_id_decode
    import irq_retire_pkg::*;
(
    input  logic                  valid,
    input  logic [ID_W-1:0]       raw,
    input  logic                  wide,
    output id_req_t               req
);
    always_comb begin
        req.valid   = valid;
        req.id      = mask_id(raw, wide);
        req.special = is_special(req.id);
    end
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack
    import irq_retire_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic       pop,
    input  stack_ent_t push_ent,
    output stack_ent_t top_ent,
    output logic       empty,
    output logic       full
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    stack_ent_t       mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] top_c;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] nxt_idx;

    assign top_c   = cnt - CNT_W'(1);
    assign top_idx = top_c[IDX_W-1:0];
    assign nxt_idx = cnt[IDX_W-1:0];
    assign empty   = (cnt == '0);
    assign full    = (cnt == DEPTH_C);
    assign top_ent = empty ? '0 : mem[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            unique case ({push, pop})
                2'b10: begin
                    mem[nxt_idx] <= push_ent;
                    cnt          <= cnt + CNT_W'(1);
                end
                2'b01: cnt <= cnt - CNT_W'(1);
                2'b11: mem[top_idx] <= push_ent;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_active_flags.sv
module irq_active_flags
    import irq_retire_pkg::*;
#(
    parameter int TRACK = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_v,
    input  irq_id_t          set_id,
    input  logic             clr_a_v,
    input  irq_id_t          clr_a_id,
    input  logic             clr_b_v,
    input  irq_id_t          clr_b_id,
    output logic [TRACK-1:0] flags
);
    for (genvar g = 0; g < TRACK; g++) begin : g_flag
        localparam irq_id_t MY_ID = irq_id_t'(g);
        logic set_hit, clr_hit;
        assign set_hit = set_v && (set_id == MY_ID);
        assign clr_hit = (clr_a_v && (clr_a_id == MY_ID)) ||
                         (clr_b_v && (clr_b_id == MY_ID));
        always_ff @(posedge clk) begin
            if (rst)          flags[g] <= 1'b0;
            else if (set_hit) flags[g] <= 1'b1;
            else if (clr_hit) flags[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_retire_tracker.sv
module irq_retire_tracker
    import irq_retire_pkg::*;
#(
    parameter int STACK_DEPTH = 8,
    parameter int TRACK_IDS   = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ack_valid,
    input  logic [23:0]          ack_id,
    input  logic [7:0]           ack_prio,
    input  logic                 eoi_valid,
    input  logic [31:0]          eoi_data,
    input  logic                 dir_valid,
    input  logic [31:0]          dir_data,
    input  logic                 split_mode,
    input  logic                 id_wide,
    output logic [7:0]           run_prio,
    output logic [TRACK_IDS-1:0] active,
    output logic                 eoi_err
);
    id_req_t    ack_req, eoi_req, dir_req;
    stack_ent_t stk_top, stk_in;
    logic       stk_empty, stk_full;
    logic       push, pop, ack_ok, ack_over;
    logic       clr_split_v;
    eoi_kind_e  eoi_kind;
    logic       unused_rsvd;

    assign unused_rsvd = ^{eoi_data[31:24], dir_data[31:24]};

    irq_id_decode u_ack_dec (.valid(ack_valid), .raw(ack_id),         .wide(id_wide), .req(ack_req));
    irq_id_decode u_eoi_dec (.valid(eoi_valid), .raw(eoi_data[23:0]), .wide(id_wide), .req(eoi_req));
    irq_id_decode u_dir_dec (.valid(dir_valid), .raw(dir_data[23:0]), .wide(id_wide), .req(dir_req));

    always_comb begin
        if (!eoi_req.valid)                              eoi_kind = EOI_IDLE;
        else if (eoi_req.special)                        eoi_kind = EOI_IGNORE;
        else if (!stk_empty && stk_top.id == eoi_req.id) eoi_kind = EOI_MATCH;
        else                                             eoi_kind = EOI_FAULT;
    end

    assign pop         = (eoi_kind == EOI_MATCH);
    assign ack_ok      = ack_req.valid && !ack_req.special;
    assign push        = ack_ok && (!stk_full || pop);
    assign ack_over    = ack_ok && stk_full && !pop;
    assign stk_in      = '{id: ack_req.id, prio: irq_prio_t'(ack_prio)};
    assign clr_split_v = dir_req.valid && !dir_req.special && split_mode;

    irq_prio_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .push_ent (stk_in),
        .top_ent  (stk_top),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    irq_active_flags #(.TRACK(TRACK_IDS)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_v    (push),
        .set_id   (ack_req.id),
        .clr_a_v  (pop && !split_mode),
        .clr_a_id (eoi_req.id),
        .clr_b_v  (clr_split_v),
        .clr_b_id (dir_req.id),
        .flags    (active)
    );

    assign run_prio = stk_empty ? IDLE_PRIO : stk_top.prio;

    always_ff @(posedge clk) begin
        if (rst) eoi_err <= 1'b0;
        else     eoi_err <= (eoi_kind == EOI_FAULT) || ack_over;
    end
endmodule

// File: rtl/irq_retire_chk.sv
module irq_retire_chk #(
    parameter int TRACK_IDS = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ack_valid,
    input logic [23:0]          ack_id,
    input logic                 eoi_valid,
    input logic [23:0]          eoi_low,
    input logic                 dir_valid,
    input logic                 split_mode,
    input logic                 id_wide,
    input logic [7:0]           run_prio,
    input logic [TRACK_IDS-1:0] active,
    input logic                 eoi_err
);
    logic [23:0] eoi_id_m, ack_id_m;
    logic        eoi_spec, ack_spec;

    assign eoi_id_m = id_wide ? eoi_low : {8'h00, eoi_low[15:0]};
    assign ack_id_m = id_wide ? ack_id  : {8'h00, ack_id[15:0]};
    assign eoi_spec = (eoi_id_m >= 24'd1020) && (eoi_id_m <= 24'd1023);
    assign ack_spec = (ack_id_m >= 24'd1020) && (ack_id_m <= 24'd1023);

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        eoi_err |-> $past(eoi_valid || ack_valid));

    // R8
    eoi_special_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && eoi_spec && !ack_valid && !dir_valid)
        |=> ($stable(run_prio) && $stable(active) && !eoi_err));

    // R2
    ack_special_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_spec && !eoi_valid && !dir_valid)
        |=> ($stable(run_prio) && $stable(active) && !eoi_err));

    // R7
    dir_unsplit_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_valid && !split_mode && !eoi_valid && !ack_valid)
        |=> ($stable(active) && $stable(run_prio)));

    // R6
    eoi_split_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && split_mode && !ack_valid && !dir_valid) |=> $stable(active));

    // R4
    prio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_valid && !eoi_valid) |=> $stable(run_prio));
endmodule

bind irq_retire_tracker irq_retire_chk #(.TRACK_IDS(TRACK_IDS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ack_valid  (ack_valid),
    .ack_id     (ack_id),
    .eoi_valid  (eoi_valid),
    .eoi_low    (eoi_data[23:0]),
    .dir_valid  (dir_valid),
    .split_mode (split_mode),
    .id_wide    (id_wide),
    .run_prio   (run_prio),
    .active     (active),
    .eoi_err    (eoi_err)
);

// File: tb/sim_irq_retire_tracker.sv
`timescale 1ns/1ps
module sim_irq_retire_tracker;
    localparam int TRACK = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ack_valid = 0, eoi_valid = 0, dir_valid = 0;
    logic [23:0]      ack_id = '0;
    logic [7:0]       ack_prio = '0;
    logic [31:0]      eoi_data = '0, dir_data = '0;
    logic             split_mode = 0, id_wide = 1;
    logic [7:0]       run_prio;
    logic [TRACK-1:0] active;
    logic             eoi_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_retire_tracker #(.STACK_DEPTH(8), .TRACK_IDS(TRACK)) u0 (
        .clk(clk), .rst(rst), .ack_valid(ack_valid), .ack_id(ack_id), .ack_prio(ack_prio),
        .eoi_valid(eoi_valid), .eoi_data(eoi_data), .dir_valid(dir_valid), .dir_data(dir_data),
        .split_mode(split_mode), .id_wide(id_wide), .run_prio(run_prio), .active(active),
        .eoi_err(eoi_err)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic state(input string req, input logic [7:0] prio, input logic [31:0] act_exp, input logic err);
        chk(req, "run_prio", {24'h0, run_prio}, {24'h0, prio});
        chk(req, "active",   active, act_exp);
        chk(req, "eoi_err",  {31'h0, eoi_err}, {31'h0, err});
    endtask

    task automatic ack(input logic [23:0] id, input logic [7:0] p);
        ack_valid = 1; ack_id = id; ack_prio = p;
        @(negedge clk);
        ack_valid = 0;
    endtask

    task automatic eoi(input logic [31:0] d);
        eoi_valid = 1; eoi_data = d;
        @(negedge clk);
        eoi_valid = 0;
    endtask

    task automatic dir(input logic [31:0] d);
        dir_valid = 1; dir_data = d;
        @(negedge clk);
        dir_valid = 0;
    endtask

    task automatic t_reset;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        state("R1", 8'hFF, 32'h0, 1'b0);
    endtask

    task automatic t_nested;
        split_mode = 0; id_wide = 1;
        ack(5, 8'h40);  state("R2", 8'h40, 32'h20, 0);
        ack(9, 8'h20);  state("R2", 8'h20, 32'h220, 0);
        eoi(9);         state("R4 R5", 8'h40, 32'h20, 0);
        eoi(5);         state("R4 R5", 8'hFF, 32'h0, 0);
    endtask

    task automatic t_split;
        split_mode = 1;
        ack(3, 8'h30);
        eoi(3);         state("R6", 8'hFF, 32'h8, 0);
        dir(7);         state("R7", 8'hFF, 32'h8, 0);
        dir(32'h3FD);   state("R7", 8'hFF, 32'h8, 0);
        dir(3);         state("R6", 8'hFF, 32'h0, 0);
        ack(4, 8'h10);
        split_mode = 0;
        dir(4);         state("R7", 8'h10, 32'h10, 0);
        eoi(4);         state("R5", 8'hFF, 32'h0, 0);
    endtask

    task automatic t_special;
        split_mode = 0;
        ack(1020, 8'h11); state("R2", 8'hFF, 32'h0, 0);
        ack(2, 8'h50);
        eoi(32'h3FF);     state("R8", 8'h50, 32'h4, 0);
        eoi(2);           state("R4", 8'hFF, 32'h0, 0);
    endtask

    task automatic t_fault;
        eoi(6);           state("R9", 8'hFF, 32'h0, 1);
        @(negedge clk);   state("R9", 8'hFF, 32'h0, 0);
        ack(6, 8'h60);
        eoi(8);           state("R9", 8'h60, 32'h40, 1);
        eoi(6);           state("R9", 8'hFF, 32'h0, 0);
    endtask

    task automatic t_width;
        id_wide = 0;
        ack(24'hAB0005, 8'h35);   state("R3", 8'h35, 32'h20, 0);
        eoi(32'h00CD0005);        state("R3", 8'hFF, 32'h0, 0);
        ack(7, 8'h70);
        eoi(32'h000103FC);        state("R3 R8", 8'h70, 32'h80, 0);
        id_wide = 1;
        eoi(32'h000103FC);        state("R3 R9", 8'h70, 32'h80, 1);
        eoi(32'hFF000007);        state("R3", 8'hFF, 32'h0, 0);
    endtask

    task automatic t_overflow;
        logic [31:0] exp_act;
        exp_act = '0;
        for (int k = 0; k < 8; k++) begin
            ack(24'(10 + k), 8'(8'h90 - 2 * k));
            exp_act[10 + k] = 1'b1;
        end
        state("R2", 8'h82, exp_act, 0);
        ack(20, 8'h05);           state("R10", 8'h82, exp_act, 1);
        for (int k = 7; k >= 0; k--) begin
            eoi(32'(10 + k));
            exp_act[10 + k] = 1'b0;
            state("R4 R10", (k == 0) ? 8'hFF : 8'(8'h90 - 2 * (k - 1)), exp_act, 0);
        end
    endtask

    task automatic t_same_cycle;
        ack(11, 8'h44);
        ack_valid = 1; ack_id = 12; ack_prio = 8'h22;
        eoi_valid = 1; eoi_data = 11;
        @(negedge clk);
        ack_valid = 0; eoi_valid = 0;
        state("R11", 8'h22, 32'h1000, 0);
        eoi(12);                  state("R11", 8'hFF, 32'h0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired (all requirements): actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_nested;
        t_split;
        t_special;
        t_fault;
        t_width;
        t_overflow;
        t_same_cycle;
        t_reset;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule